// File: doc/BRIEF.md
# SRAM Size Probe and Test Engine

This engine works on a synchronous byte-wide SRAM port and runs in two phases. In the first phase it finds out how much memory answers. It probes upward from a start address. At each probe point it writes a four-byte signature and reads it back. The first point whose signature does not survive marks the end of usable memory. After the first probe, the probe points move onto step-aligned boundaries and advance one step at a time. Probing also stops once the next point would pass a maximum address.

In the second phase the engine tests the range it found. It first sets every byte of that range to 0xFF. It then walks upward through the range, one location at a time. At each location it confirms that the byte still holds 0xFF, which exposes any location that writes to lower addresses have disturbed. It then runs a walking one through the byte and finishes by writing zero. The engine stops at the first fault and reports a code, the failing address and a bit mask. On a clean run it reports the last usable address and the tested size. Only one memory access is in flight at any time. Reads have one cycle of latency, and the engine registers the read data before it compares.

Top module: `memtest_engine`

## Requirements
- R1: After reset, busy, done and mem_we are 0 and err_code is 0.
- R2: A start pulse is taken only when the engine is idle or done. Busy is 1 for the whole run. A start pulse that arrives while busy does not change the run or its results.
- R3: At each probe point p, the engine writes 0x00, 0xFF, 0x55 and 0xAA to p, p+1, p+2 and p+3, in that order, and then reads the four bytes back in the same order.
- R4: After the first probe passes, the next probe point is the first point rounded down to a multiple of STEP, plus STEP. Each later point is the previous one plus STEP. 0x55 is written only at p+2, so it marks each probe point.
- R5: If a probe read does not match, the end of memory is p, so last_addr = p-1. If the next probe point would be above max_addr, then last_addr = max_addr.
- R6: The fill writes 0xFF to every address from start_addr to last_addr. No write goes below start_addr.
- R7: If a location does not read 0xFF before it is first written in the check pass, the engine finishes with err_code 1, err_addr set to that location, and err_mask set to the bitwise inverse of the value read.
- R8: Each location is written with 0x01, 0x02, and so on up to 0x80, with a read-back after each write. If a read-back of bit b fails, the engine finishes with err_code 2 and err_mask equal to the value read with bit b cleared.
- R9: After the walk, the location is written with 0x00 and read back. A nonzero read finishes the run with err_code 2 and err_mask set to the value read.
- R10: A run with no fault finishes with done 1, err_code 0 and size = last_addr + 1 - start_addr. If the first probe fails, size is 0 and no location is tested.
- R11: After done rises, done, err_code, err_addr, err_mask, last_addr and size hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when the engine is idle or done |
| start_addr | input | ADDR_W | First address to probe and test |
| max_addr | input | ADDR_W | Highest address that probing may reach |
| mem_addr | output | ADDR_W | SRAM address |
| mem_we | output | 1 | SRAM write enable |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, valid one cycle after the address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has finished; results are valid |
| last_addr | output | ADDR_W | Last usable address found by probing |
| size | output | ADDR_W+1 | Number of bytes tested |
| err_code | output | 2 | 0 no fault, 1 disturbed location, 2 data fault |
| err_addr | output | ADDR_W | Address of the failing location |
| err_mask | output | 8 | Bits at fault |

## Verification
A wrong probe pointer or a wrong alignment shows up in the addresses that carry 0x55, within a few cycles of the first probe. It also gives a wrong last_addr and size when the run finishes. A wrong location pointer or a wrong walking-bit register shows up in err_addr and err_mask at the first faulty location. Each location takes 39 cycles, so that report comes within 39 cycles. The bench models a missing memory region, an address line held high, bits stuck at 1 and at 0, and a location that ignores zero writes. Each case produces a fixed code, address and mask that the bench works out in advance.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_STALE = 2'd1,
    ERR_DATA  = 2'd2
  } err_t;

  typedef enum logic [1:0] {
    CMP_SIG,
    CMP_PRE,
    CMP_WALK,
    CMP_ZERO
  } cmp_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PRD, S_PWT, S_PCK,
    S_FWR,
    S_CRD, S_CWT, S_CCK,
    S_WWR, S_WRD, S_WWT, S_WCK,
    S_DONE
  } state_t;

  // Signature byte k of a probe point
  function automatic logic [7:0] sig_byte(input logic [1:0] k);
    case (k)
      2'd0:    return 8'h00;
      2'd1:    return 8'hFF;
      2'd2:    return 8'h55;
      default: return 8'hAA;
    endcase
  endfunction

  // Bits reported as faulty for a given kind of check
  function automatic logic [7:0] fault_bits(input cmp_kind_t kind,
                                            input logic [7:0] rd,
                                            input logic [7:0] exp);
    case (kind)
      CMP_PRE:  return ~rd;
      CMP_WALK: return rd & ~exp;
      CMP_ZERO: return rd;
      default:  return rd ^ exp;
    endcase
  endfunction

endpackage

// File: rtl/memtest_rdreg.sv
module memtest_rdreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  logic [7:0] d,
  output logic [7:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 8'h00;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp
  import memtest_pkg::*;
(
  input  cmp_kind_t  kind,
  input  logic [7:0] rd,
  input  logic [7:0] exp,
  output logic       mismatch,
  output logic [7:0] mask
);
  assign mismatch = (rd != exp);
  assign mask     = fault_bits(kind, rd, exp);
endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] max_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W:0]   size,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic [7:0]        err_mask
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [AW1-1:0] STEP_X  = AW1'(STEP);
  localparam logic [AW1-1:0] ALIGN_M = ~(STEP_X - AW1'(1));

  // Next probe point: first point is rounded down, then one step on
  function automatic logic [AW1-1:0] next_point(input logic [AW1-1:0] p,
                                                input logic first);
    return (first ? (p & ALIGN_M) : p) + STEP_X;
  endfunction

  state_t          state_q;
  logic [AW1-1:0]  probe_q, cur_q, end_q;
  logic [ADDR_W-1:0] start_q, max_q;
  logic [1:0]      k_q;
  logic            first_q;
  logic [7:0]      bit_q;

  logic [AW1-1:0]  start_x, max_x, addr_x, probe_nxt, end_nxt;
  logic            fill_empty, last_loc;
  cmp_kind_t       kind;
  logic [7:0]      exp_byte, rd_q, flt_mask;
  logic            mismatch, cap;

  // Named internal events for the checker
  logic ev_pre_fail, ev_walk_fail, ev_fill_wr;

  assign start_x = {1'b0, start_q};
  assign max_x   = {1'b0, max_q};

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = 8'h00;
    addr_x    = cur_q;
    kind      = CMP_PRE;
    exp_byte  = 8'hFF;
    case (state_q)
      S_PWR: begin
        mem_we    = 1'b1;
        addr_x    = probe_q + AW1'(k_q);
        mem_wdata = sig_byte(k_q);
      end
      S_PRD, S_PWT: addr_x = probe_q + AW1'(k_q);
      S_PCK: begin
        addr_x   = probe_q + AW1'(k_q);
        kind     = CMP_SIG;
        exp_byte = sig_byte(k_q);
      end
      S_FWR: begin
        mem_we    = 1'b1;
        mem_wdata = 8'hFF;
      end
      S_WWR: begin
        mem_we    = 1'b1;
        mem_wdata = bit_q;
      end
      S_WCK: begin
        kind     = (bit_q == 8'h00) ? CMP_ZERO : CMP_WALK;
        exp_byte = bit_q;
      end
      default: ;
    endcase
  end

  assign mem_addr = addr_x[ADDR_W-1:0];
  assign cap      = (state_q == S_PWT) || (state_q == S_CWT) || (state_q == S_WWT);

  memtest_rdreg u_rdreg (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (cap),
    .d    (mem_rdata),
    .q    (rd_q)
  );

  memtest_cmp u_cmp (
    .kind    (kind),
    .rd      (rd_q),
    .exp     (exp_byte),
    .mismatch(mismatch),
    .mask    (flt_mask)
  );

  assign probe_nxt  = next_point(probe_q, first_q);
  assign end_nxt    = mismatch ? probe_q : (max_x + AW1'(1));
  assign fill_empty = (start_x >= end_nxt);
  assign last_loc   = ((cur_q + AW1'(1)) >= end_q);

  assign ev_pre_fail  = (state_q == S_CCK) && mismatch;
  assign ev_walk_fail = (state_q == S_WCK) && mismatch;
  assign ev_fill_wr   = (state_q == S_FWR);

  assign busy      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done      = (state_q == S_DONE);
  assign last_addr = ADDR_W'(end_q - AW1'(1));
  assign size      = end_q - start_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      probe_q  <= '0;
      cur_q    <= '0;
      end_q    <= '0;
      start_q  <= '0;
      max_q    <= '0;
      k_q      <= 2'd0;
      first_q  <= 1'b0;
      bit_q    <= 8'h00;
      err_code <= ERR_NONE;
      err_addr <= '0;
      err_mask <= 8'h00;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: if (start) begin
          start_q  <= start_addr;
          max_q    <= max_addr;
          probe_q  <= {1'b0, start_addr};
          end_q    <= {1'b0, start_addr};
          k_q      <= 2'd0;
          first_q  <= 1'b1;
          err_code <= ERR_NONE;
          err_addr <= '0;
          err_mask <= 8'h00;
          state_q  <= S_PWR;
        end
        S_PWR: begin
          k_q <= k_q + 2'd1;
          if (k_q == 2'd3) state_q <= S_PRD;
        end
        S_PRD: state_q <= S_PWT;
        S_PWT: state_q <= S_PCK;
        S_PCK: begin
          if (mismatch || (k_q == 2'd3 && probe_nxt > max_x)) begin
            end_q   <= end_nxt;
            cur_q   <= start_x;
            state_q <= fill_empty ? S_DONE : S_FWR;
          end else if (k_q == 2'd3) begin
            k_q     <= 2'd0;
            first_q <= 1'b0;
            probe_q <= probe_nxt;
            state_q <= S_PWR;
          end else begin
            k_q     <= k_q + 2'd1;
            state_q <= S_PRD;
          end
        end
        S_FWR: begin
          if (last_loc) begin
            cur_q   <= start_x;
            state_q <= S_CRD;
          end else begin
            cur_q <= cur_q + AW1'(1);
          end
        end
        S_CRD: state_q <= S_CWT;
        S_CWT: state_q <= S_CCK;
        S_CCK: begin
          if (mismatch) begin
            err_code <= ERR_STALE;
            err_addr <= cur_q[ADDR_W-1:0];
            err_mask <= flt_mask;
            state_q  <= S_DONE;
          end else begin
            bit_q   <= 8'h01;
            state_q <= S_WWR;
          end
        end
        S_WWR: state_q <= S_WRD;
        S_WRD: state_q <= S_WWT;
        S_WWT: state_q <= S_WCK;
        S_WCK: begin
          if (mismatch) begin
            err_code <= ERR_DATA;
            err_addr <= cur_q[ADDR_W-1:0];
            err_mask <= flt_mask;
            state_q  <= S_DONE;
          end else if (bit_q == 8'h00) begin
            if (last_loc) begin
              state_q <= S_DONE;
            end else begin
              cur_q   <= cur_q + AW1'(1);
              state_q <= S_CRD;
            end
          end else begin
            bit_q   <= bit_q << 1;
            state_q <= S_WWR;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/memtest_chk.sv
module memtest_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic [7:0]        mem_wdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] start_q,
  input logic [ADDR_W-1:0] last_addr,
  input logic [1:0]        err_code,
  input logic [ADDR_W-1:0] err_addr,
  input logic [7:0]        err_mask,
  input logic [7:0]        rd_q,
  input logic              ev_pre_fail,
  input logic              ev_walk_fail,
  input logic              ev_fill_wr
);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(start_q));

  assert_fill_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_wr |-> mem_we && mem_wdata == 8'hFF && mem_addr >= start_q);

  assert_stale_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre_fail |=> done && err_code == 2'd1 && err_mask == ~$past(rd_q)
                    && err_addr == $past(mem_addr));

  assert_walk_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_fail |=> done && err_code == 2'd2 && err_addr == $past(mem_addr));

  assert_err_only_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'd0 |-> done);

  assert_results_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(err_code) && $stable(err_addr)
                       && $stable(err_mask) && $stable(last_addr));
endmodule

bind memtest_engine memtest_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata),
  .mem_addr    (mem_addr),
  .start_q     (start_q),
  .last_addr   (last_addr),
  .err_code    (err_code),
  .err_addr    (err_addr),
  .err_mask    (err_mask),
  .rd_q        (rd_q),
  .ev_pre_fail (ev_pre_fail),
  .ev_walk_fail(ev_walk_fail),
  .ev_fill_wr  (ev_fill_wr)
);

// File: tb/memtest_engine_test.sv
module memtest_engine_test;
  localparam int AW   = 10;
  localparam int STEP = 64;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0, max_addr = '0;
  logic [AW-1:0] mem_addr;
  logic mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic busy, done;
  logic [AW-1:0] last_addr, err_addr;
  logic [AW:0] size;
  logic [1:0] err_code;
  logic [7:0] err_mask;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  memtest_engine #(.ADDR_W(AW), .STEP(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .max_addr(max_addr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .last_addr(last_addr), .size(size), .err_code(err_code),
    .err_addr(err_addr), .err_mask(err_mask));

  // SRAM model with fault options
  // 0 none, 1 address bit 4 held high, 2 bit stuck 1, 3 bit stuck 0, 4 zero writes dropped
  logic [7:0] mem [MEMN];
  int memtop = MEMN;
  int fkind = 0, faddr = 0, fbit = 0;

  function automatic int mapa(input int a);
    return (fkind == 1) ? (a | 16) : a;
  endfunction

  always @(posedge clk) begin
    int a;
    logic [7:0] v;
    a = mapa(int'(mem_addr));
    if (mem_we && a < memtop && !(fkind == 4 && a == faddr && mem_wdata == 8'h00))
      mem[a] <= mem_wdata;
    if (a >= memtop) v = 8'hA5;
    else begin
      v = mem[a];
      if (fkind == 2 && a == faddr) v = v | (8'h01 << fbit);
      if (fkind == 3 && a == faddr) v = v & ~(8'h01 << fbit);
    end
    mem_rdata <= v;
  end

  // Write monitor
  int nwr = 0, n55 = 0, below = 0;
  int sig_addr [4];
  logic [7:0] sig_data [4];
  int a55 [8];
  int mon_start = 0;
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      if (nwr < 4) begin
        sig_addr[nwr] = int'(mem_addr);
        sig_data[nwr] = mem_wdata;
      end
      nwr = nwr + 1;
      if (mem_wdata == 8'h55) begin
        if (n55 < 8) a55[n55] = int'(mem_addr);
        n55 = n55 + 1;
      end
      if (int'(mem_addr) < mon_start) below = below + 1;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  // Expected end of usable memory (exclusive), computed by stepping
  function automatic int exp_end(input int s, input int mx, input int top);
    int p = s;
    forever begin
      if (mapa(p) + 3 >= top) return p;
      p = (p / STEP) * STEP + STEP;
      if (p > mx) return mx + 1;
    end
  endfunction

  task automatic run(input int s, input int mx, input int poke);
    @(negedge clk);
    start_addr = AW'(s);
    max_addr   = AW'(mx);
    nwr = 0; n55 = 0; below = 0; mon_start = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start_addr = AW'(s ^ 32);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      start_addr = AW'(s);
    end
    while (!done) @(negedge clk);
  endtask

  task automatic expect_result(input string tag, input int s, input int e,
                               input int code, input int ea, input int em);
    check({tag, " R10 err_code"}, int'(err_code), code);
    check({tag, " R5 last_addr"}, int'(last_addr), (e - 1) & (MEMN - 1));
    check({tag, " R10 size"}, int'(size), e - s);
    check({tag, " R6 no write below start"}, below, 0);
    if (code != 0) begin
      check({tag, " err_addr"}, int'(err_addr), ea);
      check({tag, " err_mask"}, int'(err_mask), em);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e;
    for (int i = 0; i < MEMN; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 mem_we", int'(mem_we), 0);
    check("R1 err_code", int'(err_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Clean run, unaligned start, stray start while busy (R2)
    memtop = 'h200; fkind = 0;
    run('h010, 'h3FF, 100);
    e = exp_end('h010, 'h3FF, memtop);
    expect_result("clean R2", 'h010, e, 0, 0, 0);
    // R3 signature sequence
    for (int k = 0; k < 4; k++) begin
      check("R3 sig addr", sig_addr[k], 'h010 + k);
    end
    check("R3 sig 0", int'(sig_data[0]), 'h00);
    check("R3 sig 1", int'(sig_data[1]), 'hFF);
    check("R3 sig 2", int'(sig_data[2]), 'h55);
    check("R3 sig 3", int'(sig_data[3]), 'hAA);
    // R4 probe points: first, then aligned steps
    check("R4 probe count", n55, (e - (('h010 / STEP) * STEP)) / STEP + 1);
    check("R4 first point", a55[0], 'h012);
    check("R4 aligned second", a55[1], STEP + 2);
    check("R4 third", a55[2], 2 * STEP + 2);

    // R11 results hold
    repeat (30) @(negedge clk);
    check("R11 done held", int'(done), 1);
    check("R11 size held", int'(size), e - 'h010);
    check("R11 last held", int'(last_addr), e - 1);

    // R5 capped by max_addr
    memtop = MEMN;
    run('h300, 'h37F, 0);
    expect_result("cap R5", 'h300, 'h380, 0, 0, 0);

    // R10 empty: first probe fails
    memtop = 'h200;
    run('h210, 'h3FF, 0);
    expect_result("empty R10", 'h210, 'h210, 0, 0, 0);

    // R7 aliasing from address bit held high
    fkind = 1;
    run('h100, 'h3FF, 0);
    expect_result("alias R7", 'h100, exp_end('h100, 'h3FF, memtop), 1, 'h110, 'hFF);

    // R8 bit 3 stuck at 1
    fkind = 2; faddr = 'h123; fbit = 3;
    run('h100, 'h3FF, 0);
    expect_result("stuck1 R8", 'h100, exp_end('h100, 'h3FF, memtop), 2, 'h123, 'h08);

    // R9 zero write dropped leaves residue
    fkind = 4; faddr = 'h145;
    run('h100, 'h3FF, 0);
    expect_result("zero R9", 'h100, exp_end('h100, 'h3FF, memtop), 2, 'h145, 'h80);

    // R7 bit 6 stuck at 0 caught before the walk
    fkind = 3; faddr = 'h1F0; fbit = 6;
    run('h100, 'h3FF, 0);
    expect_result("stuck0 R7", 'h100, exp_end('h100, 'h3FF, memtop), 1, 'h1F0, 'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule